// File: doc/BRIEF.md
# Register Rename Map Table

This block is the register alias table of an out-of-order core. It receives one unified architectural register index, splits it into a register class (integer, floating-point, condition-code or miscellaneous) and an index relative to that class, and sends the operation to the table of that class. The integer, floating-point and condition-code classes each keep their own map table and their own free list of physical tags. The free lists are simple FIFO stubs. The miscellaneous class is hard-wired and is never renamed.

Three kinds of operation are offered. A rename reads the current tag of a register, takes a fresh tag from the class free list, and returns both tags. A lookup returns the current tag without changing anything. A direct write sets a mapping, and commit or squash recovery uses it to restore or update entries. A separate release port hands a freed tag back to the tail of the free list of a class. Rename, lookup and write results are combinational in the cycle of the request. State changes take effect at the next clock edge.

Top module: `rename_table`

## Requirements
- R1: After reset, every register of every class maps to the tag equal to its class-relative index. Each renamable free list holds, in ascending order, the tags from the class register count up to its physical count minus one.
- R2: Unified indices decode in this order: integer [0, N_INT), floating-point next (N_FP), condition-code next (N_CC), miscellaneous next (N_MISC). The class-relative index is the unified index minus the start of its class.
- R3: A rename of a non-zero renamable register returns the previous tag (the current mapping) and the new tag (the head of that class free list). From the next cycle the register maps to the new tag.
- R4: For the integer and floating-point zero registers (relative indices INT_ZERO and FP_ZERO), a rename returns the current tag as both new and previous and consumes no free tag. A direct write to them is ignored.
- R5: The condition-code class has no zero register. A rename of any condition-code register, relative index 0 included, allocates a tag.
- R6: The miscellaneous class returns its class-relative index as its tag for lookups and renames (new equals previous). A direct write raises wr_err unless its tag equals that fixed tag.
- R7: An index past the last class raises lk_err for a lookup, ren_err for a rename and wr_err for a write, and no state changes.
- R8: A lookup changes no state. A lookup of the same register in the cycle of its rename returns the pre-update tag.
- R9: A direct write to a non-zero renamable register makes that register map to the written tag from the next cycle.
- R10: ren_ready is low, and nothing is consumed, when the target class free list is empty or when a direct write is presented in the same cycle.
- R11: A release appends its tag to the tail of the free list of the class of rel_arch. Later renames receive tags in FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | ARCH_W | Unified index to rename |
| ren_ready | output | 1 | Rename accepted this cycle |
| ren_new_tag | output | TAG_W | Newly assigned tag |
| ren_prev_tag | output | TAG_W | Tag held before the rename |
| ren_err | output | 1 | Rename index decodes to no class |
| lk_arch | input | ARCH_W | Unified index to look up |
| lk_tag | output | TAG_W | Current tag of lk_arch |
| lk_err | output | 1 | Lookup index decodes to no class |
| wr_valid | input | 1 | Direct entry write |
| wr_arch | input | ARCH_W | Unified index to write |
| wr_tag | input | TAG_W | Tag to write |
| wr_err | output | 1 | Bad class or misc tag mismatch |
| rel_valid | input | 1 | Release a tag to a free list |
| rel_arch | input | ARCH_W | Any index of the receiving class |
| rel_tag | input | TAG_W | Tag being released |

## Verification
The bench uses the default parameters: 8 integer, 8 floating-point, 4 condition-code and 4 miscellaneous registers, with 16, 16 and 8 physical tags and both zero indices at 0. The condition-code list starts with only four free tags, so a short burst of renames empties it and exercises the stall and the refill through release. With a 5-bit index, codes 24 to 31 decode to no class, so the error paths are reached by random stimulus as well as by directed tests.

// File: rtl/rename_pkg.sv
package rename_pkg;

    typedef enum logic [2:0] {
        RC_INT  = 3'd0,
        RC_FP   = 3'd1,
        RC_CC   = 3'd2,
        RC_MISC = 3'd3,
        RC_NONE = 3'd4
    } reg_class_e;

endpackage

// File: rtl/rename_idx_decode.sv
module rename_idx_decode
    import rename_pkg::*;
#(
    parameter int ARCH_W = 5,
    parameter int REL_W  = 3,
    parameter int N_INT  = 8,
    parameter int N_FP   = 8,
    parameter int N_CC   = 4,
    parameter int N_MISC = 4
) (
    input  logic [ARCH_W-1:0] arch,
    output reg_class_e        cls,
    output logic [REL_W-1:0]  rel
);
    localparam int B_FP   = N_INT;
    localparam int B_CC   = B_FP + N_FP;
    localparam int B_MISC = B_CC + N_CC;
    localparam int B_END  = B_MISC + N_MISC;

    // Class ranges sit back to back in fixed order; the rest is unmapped
    always_comb begin
        int a;
        a = int'(arch);
        if (a < B_FP) begin
            cls = RC_INT;
            rel = REL_W'(a);
        end else if (a < B_CC) begin
            cls = RC_FP;
            rel = REL_W'(a - B_FP);
        end else if (a < B_MISC) begin
            cls = RC_CC;
            rel = REL_W'(a - B_CC);
        end else if (a < B_END) begin
            cls = RC_MISC;
            rel = REL_W'(a - B_MISC);
        end else begin
            cls = RC_NONE;
            rel = '0;
        end
    end
endmodule

// File: rtl/rename_class_map.sv
module rename_class_map #(
    parameter int NREG     = 8,
    parameter int NPHYS    = 16,
    parameter int TAG_W    = 4,
    parameter int REL_W    = 3,
    parameter bit HAS_ZERO = 1'b1,
    parameter int ZERO_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REL_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    input  logic             ren_req,
    input  logic [REL_W-1:0] ren_idx,
    output logic             ren_ok,
    output logic [TAG_W-1:0] ren_new,
    output logic [TAG_W-1:0] ren_prev,
    input  logic             wr_en,
    input  logic [REL_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             rel_en,
    input  logic [TAG_W-1:0] rel_tag
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int PTR_W = (NPHYS > 1) ? $clog2(NPHYS) : 1;
    localparam int CNT_W = $clog2(NPHYS + 1);
    localparam int NFREE = NPHYS - NREG;

    typedef struct packed {
        logic [NREG-1:0][TAG_W-1:0]  map;
        logic [NPHYS-1:0][TAG_W-1:0] fifo;
        logic [PTR_W-1:0]            head;
        logic [PTR_W-1:0]            tail;
        logic [CNT_W-1:0]            cnt;
    } map_state_t;

    function automatic map_state_t init_state();
        map_state_t s;
        s = '0;
        for (int i = 0; i < NREG; i++) s.map[i] = TAG_W'(i);
        for (int j = 0; j < NFREE; j++) s.fifo[j] = TAG_W'(NREG + j);
        s.tail = PTR_W'(NFREE % NPHYS);
        s.cnt  = CNT_W'(NFREE);
        return s;
    endfunction

    localparam map_state_t RST_STATE = init_state();

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NPHYS - 1)) ? '0 : p + 1'b1;
    endfunction

    map_state_t s_d, s_q;

    logic [IDX_W-1:0] lk_i, ren_i, wr_i;
    logic             lk_in, ren_in, wr_in;
    logic             ren_zero, wr_zero;
    logic             pop, push;

    assign lk_i   = lk_idx[IDX_W-1:0];
    assign ren_i  = ren_idx[IDX_W-1:0];
    assign wr_i   = wr_idx[IDX_W-1:0];
    assign lk_in  = ({1'b0, lk_idx}  < (REL_W+1)'(NREG));
    assign ren_in = ({1'b0, ren_idx} < (REL_W+1)'(NREG));
    assign wr_in  = ({1'b0, wr_idx}  < (REL_W+1)'(NREG));

    generate
        if (HAS_ZERO) begin : g_zero
            assign ren_zero = ren_in && (ren_i == IDX_W'(ZERO_IDX));
            assign wr_zero  = wr_in  && (wr_i  == IDX_W'(ZERO_IDX));
        end else begin : g_nozero
            assign ren_zero = 1'b0;
            assign wr_zero  = 1'b0;
        end
    endgenerate

    assign lk_tag   = lk_in  ? s_q.map[lk_i]  : '0;
    assign ren_prev = ren_in ? s_q.map[ren_i] : '0;
    assign ren_new  = ren_zero ? ren_prev : s_q.fifo[s_q.head];
    assign ren_ok   = ren_zero || (s_q.cnt != '0);

    always_comb begin
        s_d  = s_q;
        pop  = ren_req && ren_in && !ren_zero && (s_q.cnt != '0);
        push = rel_en && (s_q.cnt != CNT_W'(NPHYS));
        if (pop) begin
            s_d.map[ren_i] = s_q.fifo[s_q.head];
            s_d.head       = ptr_next(s_q.head);
        end
        if (wr_en && wr_in && !wr_zero) begin
            s_d.map[wr_i] = wr_tag;
        end
        if (push) begin
            s_d.fifo[s_q.tail] = rel_tag;
            s_d.tail           = ptr_next(s_q.tail);
        end
        s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST_STATE;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rename_table.sv
module rename_table
    import rename_pkg::*;
#(
    parameter int ARCH_W   = 5,
    parameter int N_INT    = 8,
    parameter int N_FP     = 8,
    parameter int N_CC     = 4,
    parameter int N_MISC   = 4,
    parameter int P_INT    = 16,
    parameter int P_FP     = 16,
    parameter int P_CC     = 8,
    parameter int INT_ZERO = 0,
    parameter int FP_ZERO  = 0,
    localparam int MAX_P01 = (P_INT > P_FP) ? P_INT : P_FP,
    localparam int MAX_P   = (MAX_P01 > P_CC) ? ((MAX_P01 > N_MISC) ? MAX_P01 : N_MISC)
                                              : ((P_CC > N_MISC) ? P_CC : N_MISC),
    localparam int TAG_W   = (MAX_P > 1) ? $clog2(MAX_P) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [ARCH_W-1:0] ren_arch,
    output logic              ren_ready,
    output logic [TAG_W-1:0]  ren_new_tag,
    output logic [TAG_W-1:0]  ren_prev_tag,
    output logic              ren_err,
    input  logic [ARCH_W-1:0] lk_arch,
    output logic [TAG_W-1:0]  lk_tag,
    output logic              lk_err,
    input  logic              wr_valid,
    input  logic [ARCH_W-1:0] wr_arch,
    input  logic [TAG_W-1:0]  wr_tag,
    output logic              wr_err,
    input  logic              rel_valid,
    input  logic [ARCH_W-1:0] rel_arch,
    input  logic [TAG_W-1:0]  rel_tag
);
    localparam int MAX_R01 = (N_INT > N_FP) ? N_INT : N_FP;
    localparam int MAX_R23 = (N_CC > N_MISC) ? N_CC : N_MISC;
    localparam int MAX_R   = (MAX_R01 > MAX_R23) ? MAX_R01 : MAX_R23;
    localparam int REL_W   = (MAX_R > 1) ? $clog2(MAX_R) : 1;
    localparam int N_CLS   = 3;

    localparam int NREG_A [N_CLS] = '{N_INT, N_FP, N_CC};
    localparam int NPHY_A [N_CLS] = '{P_INT, P_FP, P_CC};
    localparam bit HASZ_A [N_CLS] = '{1'b1, 1'b1, 1'b0};
    localparam int ZIDX_A [N_CLS] = '{INT_ZERO, FP_ZERO, 0};

    reg_class_e       cls_ren, cls_lk, cls_wr, cls_rel;
    logic [REL_W-1:0] rel_ren, rel_lk, rel_wr, rel_rel;

    rename_idx_decode #(.ARCH_W(ARCH_W), .REL_W(REL_W), .N_INT(N_INT), .N_FP(N_FP),
                        .N_CC(N_CC), .N_MISC(N_MISC))
        u_dec_ren (.arch(ren_arch), .cls(cls_ren), .rel(rel_ren));
    rename_idx_decode #(.ARCH_W(ARCH_W), .REL_W(REL_W), .N_INT(N_INT), .N_FP(N_FP),
                        .N_CC(N_CC), .N_MISC(N_MISC))
        u_dec_lk (.arch(lk_arch), .cls(cls_lk), .rel(rel_lk));
    rename_idx_decode #(.ARCH_W(ARCH_W), .REL_W(REL_W), .N_INT(N_INT), .N_FP(N_FP),
                        .N_CC(N_CC), .N_MISC(N_MISC))
        u_dec_wr (.arch(wr_arch), .cls(cls_wr), .rel(rel_wr));
    rename_idx_decode #(.ARCH_W(ARCH_W), .REL_W(REL_W), .N_INT(N_INT), .N_FP(N_FP),
                        .N_CC(N_CC), .N_MISC(N_MISC))
        u_dec_rel (.arch(rel_arch), .cls(cls_rel), .rel(rel_rel));

    logic [N_CLS-1:0] ok_c;
    logic [TAG_W-1:0] new_c  [N_CLS];
    logic [TAG_W-1:0] prev_c [N_CLS];
    logic [TAG_W-1:0] lkt_c  [N_CLS];
    logic             ren_go;

    // A direct write owns the cycle; renames wait so the two never collide
    assign ren_go = ren_valid && !wr_valid;

    generate
        for (genvar g = 0; g < N_CLS; g++) begin : g_cls
            rename_class_map #(
                .NREG(NREG_A[g]), .NPHYS(NPHY_A[g]), .TAG_W(TAG_W), .REL_W(REL_W),
                .HAS_ZERO(HASZ_A[g]), .ZERO_IDX(ZIDX_A[g])
            ) u_map (
                .clk     (clk),
                .rst_n   (rst_n),
                .lk_idx  (rel_lk),
                .lk_tag  (lkt_c[g]),
                .ren_req (ren_go && (cls_ren == reg_class_e'(g))),
                .ren_idx (rel_ren),
                .ren_ok  (ok_c[g]),
                .ren_new (new_c[g]),
                .ren_prev(prev_c[g]),
                .wr_en   (wr_valid && (cls_wr == reg_class_e'(g))),
                .wr_idx  (rel_wr),
                .wr_tag  (wr_tag),
                .rel_en  (rel_valid && (cls_rel == reg_class_e'(g))),
                .rel_tag (rel_tag)
            );
        end
    endgenerate

    function automatic logic [TAG_W-1:0] misc_tag(input logic [REL_W-1:0] r);
        return TAG_W'(r);
    endfunction

    always_comb begin
        ren_ready    = !wr_valid;
        ren_new_tag  = '0;
        ren_prev_tag = '0;
        unique case (cls_ren)
            RC_INT, RC_FP, RC_CC: begin
                ren_ready    = !wr_valid && ok_c[cls_ren[1:0]];
                ren_new_tag  = new_c[cls_ren[1:0]];
                ren_prev_tag = prev_c[cls_ren[1:0]];
            end
            RC_MISC: begin
                ren_new_tag  = misc_tag(rel_ren);
                ren_prev_tag = misc_tag(rel_ren);
            end
            default: ;
        endcase
    end

    always_comb begin
        lk_tag = '0;
        unique case (cls_lk)
            RC_INT, RC_FP, RC_CC: lk_tag = lkt_c[cls_lk[1:0]];
            RC_MISC:              lk_tag = misc_tag(rel_lk);
            default: ;
        endcase
    end

    assign ren_err = ren_valid && (cls_ren == RC_NONE);
    assign lk_err  = (cls_lk == RC_NONE);
    assign wr_err  = wr_valid && ((cls_wr == RC_NONE) ||
                     ((cls_wr == RC_MISC) && (wr_tag != misc_tag(rel_wr))));
endmodule

// File: rtl/rename_table_chk.sv
module rename_table_chk #(
    parameter int ARCH_W   = 5,
    parameter int TAG_W    = 4,
    parameter int N_INT    = 8,
    parameter int N_FP     = 8,
    parameter int N_CC     = 4,
    parameter int N_MISC   = 4,
    parameter int INT_ZERO = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ren_valid,
    input logic [ARCH_W-1:0] ren_arch,
    input logic              ren_ready,
    input logic [TAG_W-1:0]  ren_new_tag,
    input logic [TAG_W-1:0]  ren_prev_tag,
    input logic              ren_err,
    input logic [ARCH_W-1:0] lk_arch,
    input logic [TAG_W-1:0]  lk_tag,
    input logic              lk_err,
    input logic              wr_valid
);
    localparam int B_MISC = N_INT + N_FP + N_CC;
    localparam int B_END  = B_MISC + N_MISC;

    logic ren_fire;
    assign ren_fire = ren_valid && ren_ready && !ren_err;

    assert_write_blocks_rename_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !ren_ready);

    assert_zero_reg_same_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && int'(ren_arch) == INT_ZERO) |-> (ren_new_tag == ren_prev_tag));

    assert_int_rename_fresh_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && int'(ren_arch) < N_INT && int'(ren_arch) != INT_ZERO)
        |-> (ren_new_tag != ren_prev_tag));

    assert_misc_fixed_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_arch) >= B_MISC && int'(lk_arch) < B_END)
        |-> (int'(lk_tag) == int'(lk_arch) - B_MISC));

    assert_unknown_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_arch) >= B_END) |-> lk_err);

    assert_lookup_sees_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && lk_arch == ren_arch) |-> (lk_tag == ren_prev_tag));
endmodule

bind rename_table rename_table_chk #(
    .ARCH_W(ARCH_W), .TAG_W(TAG_W), .N_INT(N_INT), .N_FP(N_FP),
    .N_CC(N_CC), .N_MISC(N_MISC), .INT_ZERO(INT_ZERO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_arch(ren_arch),
    .ren_ready(ren_ready), .ren_new_tag(ren_new_tag), .ren_prev_tag(ren_prev_tag),
    .ren_err(ren_err), .lk_arch(lk_arch), .lk_tag(lk_tag), .lk_err(lk_err),
    .wr_valid(wr_valid)
);

// File: tb/rename_table_test.sv
module rename_table_test;
    localparam int CLK_PERIOD = 10;
    localparam int ARCH_W = 5;
    localparam int TAG_W  = 4;
    localparam int NREG [4] = '{8, 8, 4, 4};
    localparam int NPHY [3] = '{16, 16, 8};
    localparam int BASE [4] = '{0, 8, 16, 20};
    localparam int ZERO_INT = 0;
    localparam int ZERO_FP  = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ren_valid = 1'b0, wr_valid = 1'b0, rel_valid = 1'b0;
    logic [ARCH_W-1:0] ren_arch = '0, lk_arch = '0, wr_arch = '0, rel_arch = '0;
    logic [TAG_W-1:0]  wr_tag = '0, rel_tag = '0;
    logic              ren_ready, ren_err, lk_err, wr_err;
    logic [TAG_W-1:0]  ren_new_tag, ren_prev_tag, lk_tag;

    rename_table uut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_ready(ren_ready),
        .ren_new_tag(ren_new_tag), .ren_prev_tag(ren_prev_tag), .ren_err(ren_err),
        .lk_arch(lk_arch), .lk_tag(lk_tag), .lk_err(lk_err),
        .wr_valid(wr_valid), .wr_arch(wr_arch), .wr_tag(wr_tag), .wr_err(wr_err),
        .rel_valid(rel_valid), .rel_arch(rel_arch), .rel_tag(rel_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int mmap [3][8];
    int fq   [3][$];
    int pend [3][$];

    task automatic chk(input bit ok, input string lbl, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", lbl, act, exp);
        end
    endtask

    function automatic void dec(input int a, output int c, output int r);
        c = 4; r = 0;
        for (int k = 0; k < 4; k++)
            if (a >= BASE[k] && a < BASE[k] + NREG[k]) begin c = k; r = a - BASE[k]; end
    endfunction

    function automatic bit is_zero(input int c, input int r);
        return (c == 0 && r == ZERO_INT) || (c == 1 && r == ZERO_FP);
    endfunction

    function automatic void drop(input int c, input int t);
        for (int i = 0; i < pend[c].size(); i++)
            if (pend[c][i] == t) begin pend[c].delete(i); return; end
    endfunction

    function automatic void model_reset();
        for (int c = 0; c < 3; c++) begin
            fq[c].delete(); pend[c].delete();
            for (int i = 0; i < NREG[c]; i++) mmap[c][i] = i;
            for (int t = NREG[c]; t < NPHY[c]; t++) fq[c].push_back(t);
        end
    endfunction

    // One cycle: drive at the falling edge, check the combinational results, commit at the rising edge
    task automatic step(input bit rv, input int ra, input int la,
                        input bit wv, input int wa, input int wt,
                        input bit lv, input int rla, input int rlt, input string lbl);
        int rc, rr, lc, lr, wc, wr, xc, xr, e_lk, e_new, e_prev;
        bit e_ready, rz;
        string l;
        @(negedge clk);
        ren_valid = rv; ren_arch = ARCH_W'(ra); lk_arch = ARCH_W'(la);
        wr_valid = wv; wr_arch = ARCH_W'(wa); wr_tag = TAG_W'(wt);
        rel_valid = lv; rel_arch = ARCH_W'(rla); rel_tag = TAG_W'(rlt);
        #1;
        dec(ra, rc, rr); dec(la, lc, lr); dec(wa, wc, wr); dec(rla, xc, xr);
        // lookup
        l = (lbl != "") ? lbl : (lc == 4 ? "R7" : (lc == 3 ? "R6" : "R8"));
        chk(lk_err == (lc == 4), l, int'(lk_err), int'(lc == 4));
        if (lc != 4) begin
            e_lk = (lc < 3) ? mmap[lc][lr] : lr;
            chk(int'(lk_tag) == e_lk, l, int'(lk_tag), e_lk);
        end
        // rename
        rz = (rc < 3) && is_zero(rc, rr);
        e_ready = !wv && (rc >= 3 || rz || fq[rc].size() > 0);
        if (rv) begin
            chk(ren_ready == e_ready, (lbl != "") ? lbl : "R10", int'(ren_ready), int'(e_ready));
            chk(ren_err == (rc == 4), "R7", int'(ren_err), int'(rc == 4));
            if (e_ready && rc != 4) begin
                l = (lbl != "") ? lbl : (rc == 3 ? "R6" : (rz ? "R4" : (rc == 2 ? "R5" : "R3")));
                e_prev = (rc < 3) ? mmap[rc][rr] : rr;
                e_new  = (rc < 3 && !rz) ? fq[rc][0] : e_prev;
                chk(int'(ren_prev_tag) == e_prev, l, int'(ren_prev_tag), e_prev);
                chk(int'(ren_new_tag) == e_new, l, int'(ren_new_tag), e_new);
                if (rc < 3 && !rz) begin
                    void'(fq[rc].pop_front());
                    mmap[rc][rr] = e_new;
                    pend[rc].push_back(e_prev);
                end
            end
        end
        // direct write
        if (wv) begin
            bit e_err;
            e_err = (wc == 4) || (wc == 3 && wt != wr);
            chk(wr_err == e_err, (wc == 3) ? "R6" : "R7", int'(wr_err), int'(e_err));
            if (wc < 3 && !is_zero(wc, wr)) begin
                drop(wc, wt);
                pend[wc].push_back(mmap[wc][wr]);
                mmap[wc][wr] = wt;
            end
        end
        // release
        if (lv && xc < 3 && fq[xc].size() < NPHY[xc]) begin
            drop(xc, rlt);
            fq[xc].push_back(rlt);
        end
        @(posedge clk);
    endtask

    task automatic look(input int la, input string lbl);
        step(0, 0, la, 0, 0, 0, 0, 0, 0, lbl);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    initial begin
        int t;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: identity map after reset, all classes
        for (int a = 0; a < 24; a++) look(a, "R1");
        // R2/R7: first unmapped code and the top code
        look(24, "R7");
        look(31, "R7");
        look(19, "R2");
        look(20, "R2");

        // R3 + R8: rename int 3 with same-cycle lookup; expect new 8, prev 3
        step(1, 3, 3, 0, 0, 0, 0, 0, 0, "R8");
        look(3, "R3");
        // R4: integer zero register, then check no tag was used
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 1, 1, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 8, 8, 0, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 7, 0, 0, 0, "R4");
        look(0, "R4");

        // R5: condition-code relative 0 allocates; drain the list
        step(1, 16, 16, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 17, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 18, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 19, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R10: empty list stalls
        step(1, 16, 16, 0, 0, 0, 0, 0, 0, "R10");
        look(16, "R10");
        // R11: release a freed tag and receive it back in FIFO order
        t = pend[2][0];
        step(0, 0, 0, 0, 0, 0, 1, 18, t, "R11");
        step(1, 16, 16, 0, 0, 0, 0, 0, 0, "R11");
        chk(int'(ren_new_tag) == t, "R11", int'(ren_new_tag), t);

        // R6: misc rename, matching and mismatching writes
        step(1, 21, 21, 0, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 22, 1, 22, 2, 0, 0, 0, "R6");
        step(0, 0, 22, 1, 22, 3, 0, 0, 0, "R6");
        look(22, "R6");

        // R7: unknown class for rename and write
        step(1, 25, 25, 0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 30, 1, 0, 0, 0, "R7");

        // R9 + R10: write int 5 with a freed tag while a rename is held off
        t = pend[0][0];
        step(1, 6, 5, 1, 5, t, 0, 0, 0, "R10");
        look(5, "R9");
        chk(int'(lk_tag) == t, "R9", int'(lk_tag), t);

        // Random traffic that keeps every tag owned exactly once
        for (int i = 0; i < 4000; i++) begin
            bit rv, wv, lv;
            int ra, la, wa, wt, rla, rlt, c;
            rv = ($urandom % 2) == 1;
            ra = ($urandom % 10 == 0) ? 24 + $urandom % 8 : $urandom % 24;
            la = $urandom % 32;
            wv = 0; wa = 0; wt = 0; lv = 0; rla = 0; rlt = 0;
            if ($urandom % 10 == 0) begin
                c = $urandom % 5;
                if (c < 3 && pend[c].size() > 0) begin
                    wv = 1;
                    wa = BASE[c] + $urandom % NREG[c];
                    wt = pend[c][$urandom % pend[c].size()];
                end else if (c == 3) begin
                    wv = 1; wa = 20 + $urandom % 4; wt = $urandom % 4;
                end else if (c == 4) begin
                    wv = 1; wa = 24 + $urandom % 8; wt = $urandom % 16;
                end
            end
            if (!wv && $urandom % 3 == 0) begin
                c = $urandom % 3;
                if (pend[c].size() > 0) begin
                    lv = 1;
                    rla = BASE[c] + $urandom % NREG[c];
                    rlt = pend[c][0];
                end
            end
            step(rv, ra, la, wv, wa, wt, lv, rla, rlt, "");
        end

        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        finish_run();
    end
endmodule